// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Controller

This block contains two independent 32-bit down-counters that software controls through a word-wide register bus. Each counter has its own reload value (divisor) and its own control word. The control word picks one of three operations: copy the divisor into the counter, freeze the counter, or let it count. It also picks the tick source that paces the count. An internal prescaler derives the tick sources from the block clock. A running counter reloads itself from its divisor each time it expires, so it produces a periodic event.

Each expiry sets a sticky bit in a shared raw interrupt register. A mask register selects which raw bits reach the single interrupt output. Writing ones to the acknowledge register clears the matching raw bits. A free-running cycle counter can also be read, for time-stamping. The asynchronous active-low reset is released synchronously inside the block.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset both counters read 0 and are stopped, the raw interrupt and mask registers read 0, and `irq_o` is low.
- R2: The register byte offsets are: divisor 0/1 at 0x00/0x10, count 0/1 at 0x04/0x14, control 0/1 at 0x08/0x18, time at 0x38, mask at 0x48, acknowledge at 0x4C, raw interrupt at 0x50 and masked interrupt at 0x54. Writing a control word whose bits [1:0] are 0 copies that timer's divisor into its counter at the write edge. Reading a count offset returns the live counter value.
- R3: Control bits [1:0] = 2 start the counter and = 1 stop it. A stopped counter keeps its value.
- R4: Control bits [4:2] select the tick source. With the default parameters, code 7 ticks every cycle, code 6 every 2 cycles, code 5 every 4 cycles and code 4 every 8 cycles. Codes 0 to 3 never tick. A running counter decrements by one on each tick.
- R5: A running counter that ticks while it holds 1 (or 0) expires. It reloads its divisor in the same cycle and sets raw bit 0 (timer 0) or raw bit 1 (timer 1). Periodic reloading continues while the counter is running.
- R6: Writing the acknowledge register clears each raw bit written as 1. The acknowledge register reads 0. If an expiry and an acknowledge of the same bit fall in one cycle, the bit stays set.
- R7: The masked interrupt register reads raw AND mask (bits [1:0]). `irq_o` is high exactly when that value is nonzero, and it follows every mask or acknowledge write at the next edge.
- R8: The time register increases by exactly one every clock cycle.
- R9: Reads of unmapped or misaligned offsets return 0, and writes to them change nothing. A control write with bits [1:0] = 3 is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| irq_o | output | 1 | Interrupt: OR of the masked raw bits |

## Verification
A counter that takes a wrong value or a wrong run state shows up in the next count read. It also moves the next expiry, and that moves the raw bit and `irq_o` by the same number of ticks. A wrong prescaler phase or a wrong tick-source decode shows up as a wrong decrement over a window of 16 cycles. A lost or wrongly cleared raw bit shows up on `irq_o` one edge after the mask or acknowledge write that exposes it. The acknowledge test is placed on the exact expiry edge so that a wrong set/clear priority becomes visible.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned CTL_W    = 5;

  localparam logic [ADDR_W-1:0] OFF_DIV0  = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT0  = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_CTL0  = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_DIV1  = 7'h10;
  localparam logic [ADDR_W-1:0] OFF_CNT1  = 7'h14;
  localparam logic [ADDR_W-1:0] OFF_CTL1  = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_TIME  = 7'h38;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 7'h48;
  localparam logic [ADDR_W-1:0] OFF_ACK   = 7'h4C;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 7'h50;
  localparam logic [ADDR_W-1:0] OFF_MSKD  = 7'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int unsigned SHIFT_4 = 3,
  parameter int unsigned SHIFT_5 = 2,
  parameter int unsigned SHIFT_6 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] tick_o
);
  localparam int unsigned PRE_W = SHIFT_4;

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar k = 0; k < 3; k++) begin : g_src
    localparam int unsigned SH = (k == 0) ? SHIFT_4 : (k == 1) ? SHIFT_5 : SHIFT_6;
    assign tick_o[k] = &pre_q[SH-1:0];
  end
  assign tick_o[3] = 1'b1;
endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_i,
  input  logic         ctl_wr_i,
  input  op_e          op_i,
  input  logic [2:0]   src_sel_i,
  input  logic [3:0]   tick_src_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         adv;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    expire_o = 1'b0;
    adv      = src_sel_i[2] & tick_src_i[src_sel_i[1:0]];
    if (ctl_wr_i && op_i == OP_LOAD) begin
      cnt_d = div_i;
    end else if (run_q && adv) begin
      if (cnt_q[W-1:1] == '0) begin
        cnt_d    = div_i;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (ctl_wr_i) begin
      case (op_i)
        OP_HOLD: run_d = 1'b0;
        OP_RUN:  run_d = 1'b1;
        default: run_d = run_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;
endmodule

// File: rtl/dct_irq_ctrl.sv
module dct_irq_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] expire_i,
  input  logic         ack_wr_i,
  input  logic [N-1:0] ack_bits_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_bits_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, raw_d, mask_q, mask_d;

  always_comb begin
    raw_d  = raw_q;
    mask_d = mask_q;
    if (ack_wr_i)  raw_d  = raw_q & ~ack_bits_i;
    raw_d = raw_d | expire_i;           // a new event wins over a clear
    if (mask_wr_i) mask_d = mask_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dct_pkg::*;
#(
  parameter int unsigned SHIFT_4 = 3,
  parameter int unsigned SHIFT_5 = 2,
  parameter int unsigned SHIFT_6 = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  logic [3:0]                    ticks;
  logic [NUM_TMR-1:0][DATA_W-1:0] div_q, div_d, cnt_w;
  logic [NUM_TMR-1:0][CTL_W-1:0]  ctl_q, ctl_d;
  logic [NUM_TMR-1:0]             ctl_wr, run_w, expire_w;
  logic [NUM_TMR-1:0]             raw_w, mask_w;
  logic [DATA_W-1:0]              time_q, time_d;
  op_e                            wr_op;

  assign wr_op = op_e'(bus_wdata[1:0]);

  dct_prescaler #(
    .SHIFT_4(SHIFT_4), .SHIFT_5(SHIFT_5), .SHIFT_6(SHIFT_6)
  ) u_pre (
    .clk(clk), .rst_n(rst_n_s), .tick_o(ticks)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_DIV = (t == 0) ? OFF_DIV0 : OFF_DIV1;
    localparam logic [ADDR_W-1:0] A_CTL = (t == 0) ? OFF_CTL0 : OFF_CTL1;

    assign ctl_wr[t] = wr_en && (bus_addr == A_CTL) && (wr_op != OP_BAD);

    always_comb begin
      div_d[t] = div_q[t];
      ctl_d[t] = ctl_q[t];
      if (wr_en && bus_addr == A_DIV) div_d[t] = bus_wdata;
      if (ctl_wr[t])                  ctl_d[t] = bus_wdata[CTL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        div_q[t] <= '0;
        ctl_q[t] <= '0;
      end else begin
        div_q[t] <= div_d[t];
        ctl_q[t] <= ctl_d[t];
      end
    end

    // the tick source follows the stored control word
    dct_counter #(.W(DATA_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .div_i      (div_q[t]),
      .ctl_wr_i   (ctl_wr[t]),
      .op_i       (wr_op),
      .src_sel_i  (ctl_q[t][4:2]),
      .tick_src_i (ticks),
      .count_o    (cnt_w[t]),
      .running_o  (run_w[t]),
      .expire_o   (expire_w[t])
    );
  end

  dct_irq_ctrl #(.N(NUM_TMR)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .expire_i    (expire_w),
    .ack_wr_i    (wr_en && bus_addr == OFF_ACK),
    .ack_bits_i  (bus_wdata[NUM_TMR-1:0]),
    .mask_wr_i   (wr_en && bus_addr == OFF_MASK),
    .mask_bits_i (bus_wdata[NUM_TMR-1:0]),
    .raw_o       (raw_w),
    .mask_o      (mask_w),
    .irq_o       (irq_o)
  );

  always_comb time_d = time_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) time_q <= '0;
    else          time_q <= time_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_DIV0: bus_rdata = div_q[0];
        OFF_CNT0: bus_rdata = cnt_w[0];
        OFF_CTL0: bus_rdata = DATA_W'(ctl_q[0]);
        OFF_DIV1: bus_rdata = div_q[1];
        OFF_CNT1: bus_rdata = cnt_w[1];
        OFF_CTL1: bus_rdata = DATA_W'(ctl_q[1]);
        OFF_TIME: bus_rdata = time_q;
        OFF_MASK: bus_rdata = DATA_W'(mask_w);
        OFF_RAW:  bus_rdata = DATA_W'(raw_w);
        OFF_MSKD: bus_rdata = DATA_W'(raw_w & mask_w);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic [1:0]        raw,
  input logic [1:0]        expire,
  input logic [1:0]        run,
  input logic [DATA_W-1:0] cnt0,
  input logic [CTL_W-1:0]  ctl0,
  input logic [DATA_W-1:0] time_q
);
  logic wr_ctl0, wr_ack, wr_mask;
  assign wr_ctl0 = bus_sel && bus_wr && bus_addr == OFF_CTL0;
  assign wr_ack  = bus_sel && bus_wr && bus_addr == OFF_ACK;
  assign wr_mask = bus_sel && bus_wr && bus_addr == OFF_MASK;

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run[0] && !(wr_ctl0 && bus_wdata[1:0] == 2'd0)) |=> $stable(cnt0));

  assert_expire_sets_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    expire[0] |=> raw[0]);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_ack && bus_wdata[0] && !expire[0]) |=> !raw[0]);

  assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_mask && bus_wdata[1:0] == 2'b00) |=> !irq_o);

  assert_time_step_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> time_q == $past(time_q) + 1'b1);

  assert_bad_op_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_ctl0 && bus_wdata[1:0] == 2'd3) |=> $stable(ctl0));
endmodule

bind dual_countdown_timer dct_checker u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .raw       (raw_w),
  .expire    (expire_w),
  .run       (run_w),
  .cnt0      (cnt_w[0]),
  .ctl0      (ctl_q[0]),
  .time_q    (time_q)
);

// File: tb/dual_countdown_timer_tb.sv
module dual_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] v, a, b;

  always #10 clk = ~clk;

  dual_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [6:0] ad, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] ad, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ad;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    rd(7'h04, v); chk("R1 count0", v, 0);
    rd(7'h14, v); chk("R1 count1", v, 0);
    rd(7'h50, v); chk("R1 raw", v, 0);
    rd(7'h48, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    repeat (4) @(negedge clk);
    rd(7'h04, v); chk("R1 count0 stopped", v, 0);
  endtask

  task automatic t_load();
    wr(7'h00, 32'h1234);
    wr(7'h08, 32'h1C);
    rd(7'h04, v); chk("R2 load timer0", v, 32'h1234);
    rd(7'h00, v); chk("R2 divisor0 read", v, 32'h1234);
    wr(7'h10, 32'hABCD);
    wr(7'h18, 32'h1C);
    rd(7'h14, v); chk("R2 load timer1", v, 32'hABCD);
    rd(7'h04, v); chk("R2 timer0 untouched", v, 32'h1234);
  endtask

  task automatic t_run_hold();
    wr(7'h00, 100);
    wr(7'h08, 32'h1C);
    wr(7'h08, 32'h1E);
    rd(7'h04, v); chk("R3 start value", v, 100);
    repeat (5) @(negedge clk);
    rd(7'h04, v); chk("R3 running decrement", v, 95);
    wr(7'h08, 32'h1D);                 // hold edge still counts once
    rd(7'h04, v); chk("R3 hold edge", v, 94);
    repeat (10) @(negedge clk);
    rd(7'h04, v); chk("R3 held stable", v, 94);
  endtask

  task automatic t_clksel();
    wr(7'h00, 1000);
    wr(7'h08, 32'h1D);
    wr(7'h08, 32'h1C);
    for (int code = 0; code < 8; code++) begin
      if (code == 7) continue;
      wr(7'h08, (code << 2) | 2);
      rd(7'h04, a);
      repeat (16) @(negedge clk);
      rd(7'h04, b);
      wr(7'h08, (code << 2) | 1);
      case (code)
        4: chk("R4 code4 every 8", a - b, 2);
        5: chk("R4 code5 every 4", a - b, 4);
        6: chk("R4 code6 every 2", a - b, 8);
        default: chk("R4 codes 0-3 no tick", a - b, 0);
      endcase
    end
  endtask

  task automatic t_expire();
    wr(7'h4C, 3);
    wr(7'h00, 3);
    wr(7'h08, 32'h1C);
    wr(7'h08, 32'h1E);
    rd(7'h50, v); chk("R5 raw before", v, 0);
    repeat (2) @(negedge clk);
    rd(7'h50, v); chk("R5 raw not yet", v, 0);
    rd(7'h04, v); chk("R5 count at 1", v, 1);
    @(negedge clk);
    rd(7'h50, v); chk("R5 raw set on expiry", v, 1);
    rd(7'h04, v); chk("R5 reload", v, 3);
    repeat (3) @(negedge clk);
    rd(7'h04, v); chk("R5 periodic reload", v, 3);
    wr(7'h08, 32'h1D);
    wr(7'h10, 2);
    wr(7'h18, 32'h1C);
    wr(7'h18, 32'h1E);
    repeat (2) @(negedge clk);
    rd(7'h50, v); chk("R5 timer1 sets bit1", v, 3);
    wr(7'h18, 32'h1D);
    wr(7'h4C, 1);
    rd(7'h50, v); chk("R6 ack bit0 only", v, 2);
    rd(7'h4C, v); chk("R6 ack reads zero", v, 0);
    wr(7'h4C, 2);
    rd(7'h50, v); chk("R6 ack bit1", v, 0);
  endtask

  task automatic t_collide();
    wr(7'h00, 3);
    wr(7'h08, 32'h1C);
    wr(7'h08, 32'h1E);
    repeat (2) @(negedge clk);
    wr(7'h4C, 1);                      // lands on the expiry edge
    rd(7'h50, v); chk("R6 set beats ack", v, 1);
    wr(7'h08, 32'h1D);
  endtask

  task automatic t_mask();
    chk("R7 irq masked off", {31'd0, irq_o}, 0);
    rd(7'h54, v); chk("R7 masked reg zero", v, 0);
    wr(7'h48, 1);
    chk("R7 irq on", {31'd0, irq_o}, 1);
    rd(7'h54, v); chk("R7 masked reg", v, 1);
    rd(7'h48, v); chk("R7 mask read", v, 1);
    wr(7'h48, 2);
    chk("R7 other bit mask", {31'd0, irq_o}, 0);
    wr(7'h48, 3);
    chk("R7 irq both", {31'd0, irq_o}, 1);
    wr(7'h4C, 1);
    chk("R7 irq after ack", {31'd0, irq_o}, 0);
  endtask

  task automatic t_time();
    rd(7'h38, a);
    repeat (10) @(negedge clk);
    rd(7'h38, b);
    chk("R8 time step", b - a, 10);
  endtask

  task automatic t_unmapped();
    rd(7'h20, v); chk("R9 unmapped read", v, 0);
    wr(7'h20, 32'hFFFF_FFFF);
    wr(7'h01, 32'hFFFF_FFFF);
    rd(7'h00, v); chk("R9 divisor0 untouched", v, 3);
    rd(7'h48, v); chk("R9 mask untouched", v, 3);
    rd(7'h01, v); chk("R9 misaligned read", v, 0);
    rd(7'h04, a);
    wr(7'h08, 32'h1F);
    rd(7'h08, v); chk("R9 op3 ctrl unchanged", v, 32'h1D);
    repeat (4) @(negedge clk);
    rd(7'h04, b); chk("R9 op3 count unchanged", b, a);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_run_hold();
    t_clksel();
    t_expire();
    t_collide();
    t_mask();
    t_time();
    t_unmapped();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule